// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It does this by reading a two-level page table from memory, one entry per level. A request carries the linear address, an access type (read or write) and a privilege level (user or supervisor). The block also samples a directory base value when it accepts the request. The walker reads the directory entry and checks its flags, then reads the selected table entry and checks that one too. If the walk succeeds and the accessed or dirty bits must change, the walker writes the updated entries back to memory. It then reports the physical address, the cache-disable and write-through attributes of the final entry, and a status code.

All memory traffic goes through one request/response port that uses valid/ready handshakes in both directions. The memory may insert any number of wait cycles on either side. One walk is in flight at a time. A new request is taken only while the walker is idle, and every walk ends with a single-cycle completion pulse.

Top module: `xw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `done` and `mem_req_valid` are both 0.
- R2: The directory entry is read from `{dir_base[31:12], vaddr[31:22], 2'b00}`. The table entry is read from `{dir_entry[31:12], vaddr[21:12], 2'b00}`. Bits 11..0 of `dir_base` have no effect.
- R3: Entry flags sit at these bit positions: present 0, writable 1, user 2, write-through 3, cache-disable 4, accessed 5, dirty 6. A walk with no fault reports status 0 and physical address `{table_entry[31:12], vaddr[11:0]}`. It also reports `done_nocache` equal to bit 4 and `done_wthru` equal to bit 3 of the table entry.
- R4: If the present bit of the directory entry is clear, the walk reports status 1 after that single read. If the present bit of the table entry is clear, the walk reports status 1 after two reads. A not-present walk writes nothing to memory.
- R5: A write request to an entry with bit 1 clear reports status 2, and so does a user request to an entry with bit 2 clear. This check applies at either level. At the directory level it ends the walk before the table read. Not-present takes precedence over protection, and a protection fault writes nothing to memory.
- R6: After a walk with no fault, each entry used by the walk has bit 5 set, and on a write request the table entry also has bit 6 set. All other bits are kept. An entry is written back only if its value changes, and each such entry is written exactly once.
- R7: `done` is high for exactly one cycle per walk. `req_ready` is high only while idle, so a request held during a walk is taken only after `done`. The results hold their values until the next `done`.
- R8: While a memory request waits for `mem_req_ready`, it keeps its address, write enable and write data stable. `mem_rsp_ready` is never high while a request is outstanding on the request channel.
- R9: When the status is nonzero, `done_paddr`, `done_nocache` and `done_wthru` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle; accepts a request |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user-level access |
| dir_base | input | 32 | Directory base; bits 31..12 used, sampled on accept |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Entry address |
| mem_req_we | output | 1 | 1 = entry write-back, 0 = entry read |
| mem_req_wdata | output | 32 | Updated entry for a write-back |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker takes read data |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle completion pulse |
| done_paddr | output | 32 | Physical address |
| done_nocache | output | 1 | Cache-disable bit of the table entry |
| done_wthru | output | 1 | Write-through bit of the table entry |
| done_fault | output | 2 | 0 ok, 1 not present, 2 protection |

## Verification
A request can arrive in the same cycle as the completion pulse of the previous walk, and the walker must then neither accept it nor lose it. The bench provokes this by driving several walks back to back with `req_valid` held high throughout, including over each `done` cycle. The scoreboard judges the result: each walk's status, address, attributes, read count, write count and memory entry contents must match the expected item the driver queued, in order. A second overlap occurs when both entries need a write-back in the same walk. The scoreboard checks this by the number of writes and by the final value of both entries.

// File: rtl/xw_pkg.sv
`timescale 1ns/1ps
package xw_pkg;
   // entry flag positions: fixed, the walker decodes them
   localparam int unsigned F_PRESENT = 0;
   localparam int unsigned F_WRITE   = 1;
   localparam int unsigned F_USER    = 2;
   localparam int unsigned F_WTHRU   = 3;
   localparam int unsigned F_NOCACHE = 4;
   localparam int unsigned F_ACC     = 5;
   localparam int unsigned F_DIRTY   = 6;
   localparam int unsigned F_TOP     = 11;

   typedef enum logic [1:0] {
      XW_OK      = 2'd0,
      XW_NOTPRES = 2'd1,
      XW_PROT    = 2'd2
   } xw_fault_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RD_DIR,
      S_CHK_DIR,
      S_RD_TBL,
      S_CHK_TBL,
      S_WB,
      S_DONE
   } xw_state_e;
endpackage

// File: rtl/xw_entry_chk.sv
`timescale 1ns/1ps
// Flag check and accessed/dirty update for one table level.
module xw_entry_chk
   import xw_pkg::*;
#(
   parameter int unsigned ENT_W = 32,
   parameter bit          LEAF  = 1'b0
) (
   input  logic [ENT_W-1:0] ent,
   input  logic             wr,
   input  logic             usr,
   output xw_fault_e        fault,
   output logic [ENT_W-1:0] ent_upd,
   output logic             chg
);
   generate
      if (ENT_W <= F_TOP) begin : g_bad_width
         $error("xw_entry_chk: ENT_W too small for the flag field");
      end
   endgenerate

   logic deny;

   always_comb begin
      deny = (wr && !ent[F_WRITE]) || (usr && !ent[F_USER]);
      if (!ent[F_PRESENT]) begin
         fault = XW_NOTPRES;
      end else if (deny) begin
         fault = XW_PROT;
      end else begin
         fault = XW_OK;
      end
   end

   generate
      if (LEAF) begin : g_leaf
         always_comb begin
            ent_upd          = ent;
            ent_upd[F_ACC]   = 1'b1;
            ent_upd[F_DIRTY] = ent[F_DIRTY] | wr;
         end
      end else begin : g_inner
         always_comb begin
            ent_upd        = ent;
            ent_upd[F_ACC] = 1'b1;
         end
      end
   endgenerate

   assign chg = (ent_upd != ent);
endmodule

// File: rtl/xw_idx_addr.sv
`timescale 1ns/1ps
// Forms an entry address: aligned base, index scaled by the entry size.
module xw_idx_addr #(
   parameter int unsigned PA_W  = 32,
   parameter int unsigned OFF_W = 12,
   parameter int unsigned IDX_W = 10
) (
   input  logic [PA_W-1:0]  base,
   input  logic [IDX_W-1:0] idx,
   output logic [PA_W-1:0]  addr
);
   localparam int unsigned PAD_W = OFF_W - IDX_W - 2;

   logic unused_base_lo;
   assign unused_base_lo = ^base[OFF_W-1:0];

   generate
      if (OFF_W < IDX_W + 2) begin : g_bad_idx
         $error("xw_idx_addr: table does not fit in one page");
      end else if (PAD_W == 0) begin : g_full
         assign addr = {base[PA_W-1:OFF_W], idx, 2'b00};
      end else begin : g_pad
         assign addr = {base[PA_W-1:OFF_W], {PAD_W{1'b0}}, idx, 2'b00};
      end
   endgenerate
endmodule

// File: rtl/xw_walker.sv
`timescale 1ns/1ps
module xw_walker
   import xw_pkg::*;
#(
   parameter int unsigned VA_W  = 32,
   parameter int unsigned PA_W  = 32,
   parameter int unsigned OFF_W = 12,
   parameter int unsigned IDX_W = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_vaddr,
   input  logic            req_write,
   input  logic            req_user,
   input  logic [PA_W-1:0] dir_base,
   output logic            mem_req_valid,
   input  logic            mem_req_ready,
   output logic [PA_W-1:0] mem_req_addr,
   output logic            mem_req_we,
   output logic [PA_W-1:0] mem_req_wdata,
   input  logic            mem_rsp_valid,
   output logic            mem_rsp_ready,
   input  logic [PA_W-1:0] mem_rsp_data,
   output logic            done,
   output logic [PA_W-1:0] done_paddr,
   output logic            done_nocache,
   output logic            done_wthru,
   output logic [1:0]      done_fault
);
   localparam int unsigned DIR_LSB = OFF_W + IDX_W;
   localparam int unsigned N_LVL   = 2;

   generate
      if (VA_W != OFF_W + N_LVL * IDX_W) begin : g_bad_split
         $error("xw_walker: VA_W must equal OFF_W + 2*IDX_W");
      end
      if (OFF_W <= F_TOP) begin : g_bad_off
         $error("xw_walker: OFF_W must cover the flag field");
      end
   endgenerate

   xw_state_e       state_q;
   logic [VA_W-1:0] va_q;
   logic            wr_q;
   logic            usr_q;
   logic [PA_W-1:0] base_q;
   logic [PA_W-1:0] dir_ent_q;
   logic [PA_W-1:0] tbl_ent_q;
   logic            issued_q;
   logic            wb_tbl_q;
   logic [PA_W-1:0] res_paddr_q;
   logic            res_nc_q;
   logic            res_wt_q;
   xw_fault_e       res_fault_q;

   logic [PA_W-1:0] dir_addr;
   logic [PA_W-1:0] tbl_addr;
   logic [PA_W-1:0] ent_v [N_LVL];
   logic [PA_W-1:0] upd_v [N_LVL];
   xw_fault_e       flt_v [N_LVL];
   logic            chg_v [N_LVL];
   logic            rd_phase;

   // address formers for both levels
   xw_idx_addr #(.PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dir_addr (
      .base (base_q),
      .idx  (va_q[DIR_LSB +: IDX_W]),
      .addr (dir_addr)
   );

   xw_idx_addr #(.PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tbl_addr (
      .base (dir_ent_q),
      .idx  (va_q[OFF_W +: IDX_W]),
      .addr (tbl_addr)
   );

   assign ent_v[0] = dir_ent_q;
   assign ent_v[1] = tbl_ent_q;

   // one flag checker per level; the last level also updates dirty
   generate
      for (genvar lv = 0; lv < N_LVL; lv++) begin : g_lvl
         xw_entry_chk #(.ENT_W(PA_W), .LEAF(lv == N_LVL - 1)) u_chk (
            .ent     (ent_v[lv]),
            .wr      (wr_q),
            .usr     (usr_q),
            .fault   (flt_v[lv]),
            .ent_upd (upd_v[lv]),
            .chg     (chg_v[lv])
         );
      end
   endgenerate

   // memory port
   assign rd_phase = (state_q == S_RD_DIR) || (state_q == S_RD_TBL);

   always_comb begin
      mem_req_valid = (rd_phase && !issued_q) || (state_q == S_WB);
      mem_req_we    = (state_q == S_WB);
      mem_rsp_ready = rd_phase && issued_q;
      if (state_q == S_RD_TBL || (state_q == S_WB && wb_tbl_q)) begin
         mem_req_addr = tbl_addr;
      end else begin
         mem_req_addr = dir_addr;
      end
      mem_req_wdata = wb_tbl_q ? upd_v[1] : upd_v[0];
   end

   assign req_ready    = (state_q == S_IDLE);
   assign done         = (state_q == S_DONE);
   assign done_paddr   = res_paddr_q;
   assign done_nocache = res_nc_q;
   assign done_wthru   = res_wt_q;
   assign done_fault   = res_fault_q;

   // walk sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         va_q        <= '0;
         wr_q        <= 1'b0;
         usr_q       <= 1'b0;
         base_q      <= '0;
         dir_ent_q   <= '0;
         tbl_ent_q   <= '0;
         issued_q    <= 1'b0;
         wb_tbl_q    <= 1'b0;
         res_paddr_q <= '0;
         res_nc_q    <= 1'b0;
         res_wt_q    <= 1'b0;
         res_fault_q <= XW_OK;
      end else begin
         unique case (state_q)
            S_IDLE: begin
               if (req_valid) begin
                  va_q     <= req_vaddr;
                  wr_q     <= req_write;
                  usr_q    <= req_user;
                  base_q   <= dir_base;
                  issued_q <= 1'b0;
                  state_q  <= S_RD_DIR;
               end
            end
            S_RD_DIR: begin
               if (!issued_q) begin
                  if (mem_req_ready) issued_q <= 1'b1;
               end else if (mem_rsp_valid) begin
                  dir_ent_q <= mem_rsp_data;
                  issued_q  <= 1'b0;
                  state_q   <= S_CHK_DIR;
               end
            end
            S_CHK_DIR: begin
               if (flt_v[0] != XW_OK) begin
                  res_paddr_q <= '0;
                  res_nc_q    <= 1'b0;
                  res_wt_q    <= 1'b0;
                  res_fault_q <= flt_v[0];
                  state_q     <= S_DONE;
               end else begin
                  state_q <= S_RD_TBL;
               end
            end
            S_RD_TBL: begin
               if (!issued_q) begin
                  if (mem_req_ready) issued_q <= 1'b1;
               end else if (mem_rsp_valid) begin
                  tbl_ent_q <= mem_rsp_data;
                  issued_q  <= 1'b0;
                  state_q   <= S_CHK_TBL;
               end
            end
            S_CHK_TBL: begin
               if (flt_v[1] != XW_OK) begin
                  res_paddr_q <= '0;
                  res_nc_q    <= 1'b0;
                  res_wt_q    <= 1'b0;
                  res_fault_q <= flt_v[1];
                  state_q     <= S_DONE;
               end else begin
                  res_paddr_q <= {tbl_ent_q[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
                  res_nc_q    <= tbl_ent_q[F_NOCACHE];
                  res_wt_q    <= tbl_ent_q[F_WTHRU];
                  res_fault_q <= XW_OK;
                  if (chg_v[0] || chg_v[1]) begin
                     wb_tbl_q <= !chg_v[0];
                     state_q  <= S_WB;
                  end else begin
                     state_q <= S_DONE;
                  end
               end
            end
            S_WB: begin
               if (mem_req_ready) begin
                  if (!wb_tbl_q && chg_v[1]) begin
                     wb_tbl_q <= 1'b1;
                  end else begin
                     wb_tbl_q <= 1'b0;
                     state_q  <= S_DONE;
                  end
               end
            end
            S_DONE: begin
               state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xw_walk_chk.sv
`timescale 1ns/1ps
module xw_walk_chk #(
   parameter int unsigned PA_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [PA_W-1:0] mem_req_addr,
   input logic            mem_req_we,
   input logic [PA_W-1:0] mem_req_wdata,
   input logic            mem_rsp_ready,
   input logic            done,
   input logic [PA_W-1:0] done_paddr,
   input logic            done_nocache,
   input logic            done_wthru,
   input logic [1:0]      done_fault
);
   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   done_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_ready);

   // R7
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)
          && $stable(mem_req_wdata)));

   // R8
   rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_ready |-> !mem_req_valid);

   // R6
   wb_accessed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_we) |-> mem_req_wdata[5]);

   // R9
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_fault != 2'd0) |->
         (done_paddr == '0 && !done_nocache && !done_wthru));
endmodule

bind xw_walker xw_walk_chk #(.PA_W(PA_W)) u_walk_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .mem_req_we    (mem_req_we),
   .mem_req_wdata (mem_req_wdata),
   .mem_rsp_ready (mem_rsp_ready),
   .done          (done),
   .done_paddr    (done_paddr),
   .done_nocache  (done_nocache),
   .done_wthru    (done_wthru),
   .done_fault    (done_fault)
);

// File: tb/test_xw_walker.sv
`timescale 1ns/1ps
module test_xw_walker;
   localparam logic [31:0] FP = 32'h1, FW = 32'h2, FU = 32'h4, FWT = 32'h8;
   localparam logic [31:0] FCD = 32'h10, FA = 32'h20, FD = 32'h40;
   localparam logic [31:0] DBASE = 32'h0001_0ABC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic [31:0] dir_base = DBASE;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_req_we;
   logic [31:0] mem_req_wdata;
   logic        mem_rsp_valid = 1'b0;
   logic        mem_rsp_ready;
   logic [31:0] mem_rsp_data = '0;
   logic        done;
   logic [31:0] done_paddr;
   logic        done_nocache;
   logic        done_wthru;
   logic [1:0]  done_fault;

   always #4 clk = ~clk;

   xw_walker i_xw_walker (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_user(req_user), .dir_base(dir_base),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_req_we(mem_req_we),
      .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
      .done(done), .done_paddr(done_paddr), .done_nocache(done_nocache),
      .done_wthru(done_wthru), .done_fault(done_fault)
   );

   int n_tests = 0;
   int n_fail  = 0;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // memory model (design-facing) and bench-side expectation memory
   logic [31:0] mem [logic [31:0]];
   logic [31:0] emem [logic [31:0]];
   int          rd_cnt = 0;
   int          wr_cnt = 0;
   logic [15:0] lfsr = 16'hACE1;
   bit          pend = 1'b0;
   logic [31:0] pend_addr = '0;
   int          wait_n = 0;

   function automatic logic [31:0] mrd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   function automatic logic [31:0] erd(input logic [31:0] a);
      return emem.exists(a) ? emem[a] : 32'h0;
   endfunction

   task automatic put(input logic [31:0] a, input logic [31:0] v);
      mem[a]  = v;
      emem[a] = v;
   endtask

   always @(posedge clk) begin
      if (mem_req_valid && mem_req_ready) begin
         if (mem_req_we) begin
            mem[mem_req_addr] = mem_req_wdata;
            wr_cnt++;
         end else begin
            rd_cnt++;
            pend      = 1'b1;
            pend_addr = mem_req_addr;
            wait_n    = int'(lfsr[2:1]);
         end
      end
      if (mem_rsp_valid && mem_rsp_ready) begin
         mem_rsp_valid <= 1'b0;
      end else if (pend && !mem_rsp_valid) begin
         if (wait_n == 0) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mrd(pend_addr);
            pend = 1'b0;
         end else begin
            wait_n--;
         end
      end
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_req_ready <= lfsr[0] | lfsr[3];
   end

   // scoreboard
   typedef struct {
      logic [31:0] paddr;
      logic        nc;
      logic        wt;
      logic [1:0]  fault;
      logic [31:0] dir_a;
      logic [31:0] tbl_a;
      logic [31:0] dir_v;
      logic [31:0] tbl_v;
      bit          tbl_used;
      int          rds;
      int          wrs;
   } exp_t;

   exp_t sb[$];
   int   rd_base = 0;
   int   wr_base = 0;
   bit   hold_chk = 1'b0;
   logic [31:0] last_paddr = '0;
   logic [1:0]  last_fault = '0;

   task automatic plan(input logic [31:0] va, input bit wr, input bit usr);
      exp_t e;
      logic [31:0] d, t;
      e.dir_a = {DBASE[31:12], va[31:22], 2'b00};
      d = erd(e.dir_a);
      e.paddr = '0; e.nc = 1'b0; e.wt = 1'b0; e.wrs = 0;
      e.tbl_a = '0; e.tbl_v = '0; e.tbl_used = 1'b0;
      e.rds = 1;
      if (!d[0]) begin
         e.fault = 2'd1;
      end else if ((wr && !d[1]) || (usr && !d[2])) begin
         e.fault = 2'd2;
      end else begin
         e.tbl_a = {d[31:12], va[21:12], 2'b00};
         e.tbl_used = 1'b1;
         t = erd(e.tbl_a);
         e.rds = 2;
         if (!t[0]) begin
            e.fault = 2'd1;
         end else if ((wr && !t[1]) || (usr && !t[2])) begin
            e.fault = 2'd2;
         end else begin
            logic [31:0] nd, nt;
            e.fault = 2'd0;
            e.paddr = {t[31:12], va[11:0]};
            e.nc = t[4];
            e.wt = t[3];
            nd = d | FA;
            nt = t | FA | (wr ? FD : 32'h0);
            e.wrs = int'(nd != d) + int'(nt != t);
            emem[e.dir_a] = nd;
            emem[e.tbl_a] = nt;
         end
      end
      e.dir_v = erd(e.dir_a);
      if (e.tbl_used) e.tbl_v = erd(e.tbl_a);
      sb.push_back(e);
   endtask

   // driver: queues the expectation, then presents the request until taken
   task automatic walk(input logic [31:0] va, input bit wr, input bit usr);
      plan(va, wr, usr);
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = va;
      req_write = wr;
      req_user  = usr;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
   endtask

   task automatic idle_req();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic drain();
      while (sb.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [31:0] va(input int d, input int t, input int off);
      return {d[9:0], t[9:0], off[11:0]};
   endfunction

   // monitor
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            check("R7", "unexpected done", 32'h1, 32'h0);
         end else begin
            exp_t e;
            string rq;
            e = sb.pop_front();
            rq = (e.fault == 2'd1) ? "R4" : (e.fault == 2'd2) ? "R5" : "R3";
            check(rq, "fault", {30'h0, done_fault}, {30'h0, e.fault});
            check(e.fault != 0 ? "R9" : "R3", "paddr", done_paddr, e.paddr);
            check(e.fault != 0 ? "R9" : "R3", "nocache", {31'h0, done_nocache}, {31'h0, e.nc});
            check(e.fault != 0 ? "R9" : "R3", "wthru", {31'h0, done_wthru}, {31'h0, e.wt});
            check("R2", "reads", rd_cnt - rd_base, e.rds);
            check("R6", "writes", wr_cnt - wr_base, e.wrs);
            check("R6", "dir entry", mrd(e.dir_a), e.dir_v);
            if (e.tbl_used) check("R6", "table entry", mrd(e.tbl_a), e.tbl_v);
            rd_base    = rd_cnt;
            wr_base    = wr_cnt;
            last_paddr = done_paddr;
            last_fault = done_fault;
            hold_chk   = 1'b1;
         end
      end else if (rst_n && hold_chk) begin
         hold_chk = 1'b0;
         check("R7", "done pulse length", {31'h0, done}, 32'h0);
         check("R7", "paddr held", done_paddr, last_paddr);
         check("R7", "fault held", {30'h0, done_fault}, {30'h0, last_fault});
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
   end

   initial begin
      // directory at 0x10000, low base bits set to show they are ignored (R2)
      put(32'h0001_0004, 32'h0002_0000 | 32'hE00 | FP | FW | FU);
      put(32'h0001_0008, 32'h0000_0000);
      put(32'h0001_000C, 32'h0003_0000 | FP | FU);
      put(32'h0001_0010, 32'h0004_0000 | FP | FW);
      put(32'h0002_0014, 32'h1234_5000 | FP | FW | FU | FCD);
      put(32'h0002_0018, 32'h0ABC_D000 | FP | FW | FU | FWT | FA);
      put(32'h0002_001C, 32'h7777_7000 | FW | FU);
      put(32'h0002_0020, 32'h0888_8000 | FP | FU);
      put(32'h0003_0004, 32'h0333_3000 | FP | FW | FU);
      put(32'h0004_0008, 32'h0444_4000 | FP | FW | FU | FA | FD);

      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "req_ready at reset", {31'h0, req_ready}, 32'h1);
      check("R1", "done at reset", {31'h0, done}, 32'h0);
      check("R1", "mem_req_valid at reset", {31'h0, mem_req_valid}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      walk(va(1, 5, 12'h123), 1'b0, 1'b1); idle_req(); drain(); // R3 R6 both A set
      walk(va(1, 5, 12'h456), 1'b0, 1'b1); idle_req(); drain(); // R6 no write
      walk(va(1, 5, 12'h000), 1'b1, 1'b0); idle_req(); drain(); // R6 dirty
      walk(va(1, 5, 12'h008), 1'b1, 1'b0); idle_req(); drain(); // R6 unchanged
      walk(va(1, 6, 12'hFFF), 1'b0, 1'b1); idle_req(); drain(); // R3 write-through
      walk(va(2, 0, 12'h000), 1'b0, 1'b0); idle_req(); drain(); // R4 dir level
      walk(va(1, 7, 12'h000), 1'b0, 1'b0); idle_req(); drain(); // R4 table level
      walk(va(1, 8, 12'h010), 1'b1, 1'b1); idle_req(); drain(); // R5 table read-only
      walk(va(1, 8, 12'h010), 1'b0, 1'b1); idle_req(); drain(); // R3 read allowed
      walk(va(3, 1, 12'h000), 1'b1, 1'b0); idle_req(); drain(); // R5 dir read-only
      walk(va(3, 1, 12'h020), 1'b0, 1'b1); idle_req(); drain(); // R3
      walk(va(4, 2, 12'h000), 1'b0, 1'b1); idle_req(); drain(); // R5 supervisor dir
      walk(va(4, 2, 12'h033), 1'b0, 1'b0); idle_req(); drain(); // R6 dir only
      walk(va(4, 2, 12'h000), 1'b1, 1'b0); idle_req(); drain(); // R6 no change

      // R7 back-to-back: req_valid stays high across each done
      walk(va(3, 1, 12'h004), 1'b1, 1'b0);
      walk(va(1, 6, 12'h008), 1'b1, 1'b0);
      walk(va(2, 3, 12'h000), 1'b0, 1'b1);
      walk(va(1, 9, 12'h000), 1'b0, 1'b0);
      idle_req();
      drain();

      check("R7", "scoreboard empty", sb.size(), 32'h0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule